// File: doc/BRIEF.md
# Framed Serial Command Port

This block is the host-facing side of a segment display controller. A host drives a chip-enable, a serial clock and a data line. Each transfer opens with an 8-bit address sent least-significant bit first. One address opens a write transfer, a second opens a read transfer, and any other address makes the rest of the transfer inert. The serial lines are sampled in the `clk` domain. The serial clock is slow compared with `clk`, and its rising and falling edges are found by edge detection.

A write transfer carries one group of 42 display bits. Eight tail bits follow the display bits. The first six tail bits are control bits and the last two give the group number. The three groups together fill a 126-bit display image. Only group 0 updates the control register from its tail: sleep field, port select, segment enable and bias select. The other groups ignore their tail. A group is committed only when chip-enable drops after exactly the frame length. A short or long frame leaves all state untouched.

A read transfer takes a snapshot of the 30 key bits and the sleep-acknowledge input when the address completes. It then presents one bit on each falling serial clock edge. The data-out pin models an open-drain line: 1 means released. It stays released whenever no read bit is being presented. The serial clock may idle at either level, because data is taken only on rising edges and presented only on falling edges.

Top module: `serial_cmd_port`

## Requirements
- R1: After reset, `disp_mem`, `sleep_mode`, `port_sel`, `seg_enable` and `bias_third` are all zero and `ser_dout` is 1.
- R2: While `ser_ce` is high, the first 8 rising `ser_clk` edges shift in the address LSB first. 0x42 selects write and 0x43 selects read. Any other address changes no register and leaves `ser_dout` at 1.
- R3: In a write transfer, payload bit k is the (k+1)-th bit after the address, for k = 0..49. Bits 0..41 are display data. Bits 48..49 are the group number g (bit 48 is the LSB). On commit, payload bit k is written to `disp_mem[42*g + k]` for g = 0, 1 or 2.
- R4: A committed group 0 loads the control register from payload bits 42..47: 42 to `sleep_mode[0]`, 43 to `sleep_mode[1]`, 44 to `port_sel[0]`, 45 to `port_sel[1]`, 46 to `seg_enable`, 47 to `bias_third`. Groups 1 and 2 leave the control register unchanged.
- R5: A write commits only on the falling edge of `ser_ce`, and only if exactly 58 rising `ser_clk` edges (address plus payload) were seen. Frames of any other length are discarded, and so are frames with group number 3.
- R6: In a read transfer, `key_in` and `sleep_ack` are captured on the 8th rising edge. Each following falling edge presents the next bit on `ser_dout`: `key_in[0]` through `key_in[29]`, then `sleep_ack`.
- R7: `ser_dout` is 1 while `ser_ce` is low, throughout write transfers, and from the falling edge that follows the sleep-acknowledge bit.
- R8: Reads and writes behave the same whether `ser_clk` idles low or high between transfers.
- R9: A committed group 0 with payload bits 42 and 43 both zero clears `sleep_mode` to 0, which ends sleep.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock; serial lines are sampled on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| ser_ce | input | 1 | Chip-enable; high frames a transfer |
| ser_clk | input | 1 | Serial clock; any idle level |
| ser_din | input | 1 | Serial data in, taken on rising `ser_clk` |
| ser_dout | output | 1 | Serial data out, 1 = released, changes on falling `ser_clk` |
| key_in | input | 30 | Key state from the scanner |
| sleep_ack | input | 1 | Sleep acknowledge from the display core |
| disp_mem | output | 126 | Display image |
| sleep_mode | output | 2 | Sleep field, 0 = running |
| port_sel | output | 2 | Segment/general-output selection |
| seg_enable | output | 1 | Segment drive on |
| bias_third | output | 1 | 1 = one-third bias, 0 = one-half bias |

## Verification
The assertions check three things on every cycle. The data-out line is released after any cycle with chip-enable low. Data-out changes only after a serial clock fall or a chip-enable drop. The display image and the control register change only in the cycle after chip-enable falls. The exact bit placement, the frame-length and group-number filtering, the key snapshot and the order of read bits can only be shown by the bench. It sends complete, short, long and misaddressed frames with both clock idle levels and compares the results with its own model.

// File: rtl/scp_pkg.sv
// Shared types for the framed serial command port.
// Assumes: nothing beyond IEEE 1800-2017 packages.
package scp_pkg;

    // Control register; field order matches the tail bits of a group-0 frame.
    typedef struct packed {
        logic       bias_third;
        logic       seg_enable;
        logic [1:0] port_sel;
        logic [1:0] sleep_mode;
    } scp_ctrl_t;

    // Phase of the current chip-enable frame.
    typedef enum logic [1:0] {
        PH_ADDR  = 2'd0,
        PH_WRITE = 2'd1,
        PH_READ  = 2'd2,
        PH_SKIP  = 2'd3
    } scp_phase_e;

endpackage

// File: rtl/scp_edge_det.sv
// Finds rising and falling serial clock edges and the chip-enable drop.
// Assumes the serial lines are already synchronous to clk and that each serial
// clock level lasts at least one clk period.
module scp_edge_det (
    input  logic clk,
    input  logic rst_n,
    input  logic ser_clk,
    input  logic ser_ce,
    output logic sck_rise,
    output logic sck_fall,
    output logic ce_fall
);
    logic sck_q;
    logic ce_q;

    // Remember the previous level of both framing lines.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sck_q <= 1'b0;
            ce_q  <= 1'b0;
        end else begin
            sck_q <= ser_clk;
            ce_q  <= ser_ce;
        end
    end

    assign sck_rise = ser_ce & ser_clk & ~sck_q;
    assign sck_fall = ser_ce & ~ser_clk & sck_q;
    assign ce_fall  = ~ser_ce & ce_q;
endmodule

// File: rtl/scp_frame_rx.sv
// Receives the address and the write payload of one chip-enable frame.
// Counts rising serial clock edges and flags a read start and a write commit.
// Assumes ADDR_W >= 2; the bit counter saturates one past the full frame, so
// longer frames never match.
module scp_frame_rx
    import scp_pkg::*;
#(
    parameter int              ADDR_W  = 8,
    parameter int              PAY_W   = 50,
    parameter logic [ADDR_W-1:0] WR_ADDR = 8'h42,
    parameter logic [ADDR_W-1:0] RD_ADDR = 8'h43
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ser_ce,
    input  logic             ser_din,
    input  logic             sck_rise,
    input  logic             ce_fall,
    output logic             rd_start,
    output logic             commit,
    output logic [PAY_W-1:0] pay_q
);
    localparam int FRAME_W = ADDR_W + PAY_W;
    localparam int CNT_W   = $clog2(FRAME_W + 2);
    localparam logic [CNT_W-1:0] CNT_MAX   = CNT_W'(FRAME_W + 1);
    localparam logic [CNT_W-1:0] CNT_FULL  = CNT_W'(FRAME_W);
    localparam logic [CNT_W-1:0] ADDR_LAST = CNT_W'(ADDR_W - 1);

    logic [CNT_W-1:0]  cnt_q;
    logic [ADDR_W-1:0] addr_q;
    logic [ADDR_W-1:0] addr_next;
    scp_phase_e        phase_q;

    assign addr_next = {ser_din, addr_q[ADDR_W-1:1]};

    // Count edges, collect the address, then the payload if writing.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q   <= '0;
            addr_q  <= '0;
            pay_q   <= '0;
            phase_q <= PH_ADDR;
        end else if (!ser_ce) begin
            cnt_q   <= '0;
            phase_q <= PH_ADDR;
        end else if (sck_rise) begin
            if (cnt_q != CNT_MAX) cnt_q <= cnt_q + 1'b1;
            case (phase_q)
                PH_ADDR: begin
                    addr_q <= addr_next;
                    if (cnt_q == ADDR_LAST) begin
                        if (addr_next == WR_ADDR)      phase_q <= PH_WRITE;
                        else if (addr_next == RD_ADDR) phase_q <= PH_READ;
                        else                           phase_q <= PH_SKIP;
                    end
                end
                PH_WRITE: pay_q <= {ser_din, pay_q[PAY_W-1:1]};
                default: ;
            endcase
        end
    end

    assign rd_start = sck_rise && (phase_q == PH_ADDR) && (cnt_q == ADDR_LAST)
                      && (addr_next == RD_ADDR);
    assign commit   = ce_fall && (phase_q == PH_WRITE) && (cnt_q == CNT_FULL);
endmodule

// File: rtl/scp_read_tx.sv
// Shifts a captured word out on falling serial clock edges, LSB first.
// Holds the line released (1) outside a read or once the word is exhausted.
// Assumes load and a falling edge never occur in the same cycle.
module scp_read_tx #(
    parameter int RD_W = 31
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            ser_ce,
    input  logic            load,
    input  logic [RD_W-1:0] load_word,
    input  logic            sck_fall,
    output logic            dout
);
    localparam int LEFT_W = $clog2(RD_W + 1);

    logic [RD_W-1:0]   sh_q;
    logic [LEFT_W-1:0] left_q;

    // Snapshot on load, present one bit per fall, release otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh_q   <= '0;
            left_q <= '0;
            dout   <= 1'b1;
        end else if (!ser_ce) begin
            left_q <= '0;
            dout   <= 1'b1;
        end else if (load) begin
            sh_q   <= load_word;
            left_q <= LEFT_W'(RD_W);
        end else if (sck_fall) begin
            if (left_q != '0) begin
                dout   <= sh_q[0];
                sh_q   <= sh_q >> 1;
                left_q <= left_q - 1'b1;
            end else begin
                dout   <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/serial_cmd_port.sv
// Framed serial command port: a chip-enable framed slave that loads display
// groups and control bits, and returns key data with a sleep acknowledge.
// Assumes all inputs are synchronous to clk; ser_dout = 1 means released.
module serial_cmd_port
    import scp_pkg::*;
#(
    parameter int               ADDR_W   = 8,
    parameter int               GRP_BITS = 42,
    parameter int               NUM_GRP  = 3,
    parameter int               KEY_W    = 30,
    parameter logic [ADDR_W-1:0] WR_ADDR = 8'h42,
    parameter logic [ADDR_W-1:0] RD_ADDR = 8'h43
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        ser_ce,
    input  logic                        ser_clk,
    input  logic                        ser_din,
    output logic                        ser_dout,
    input  logic [KEY_W-1:0]            key_in,
    input  logic                        sleep_ack,
    output logic [GRP_BITS*NUM_GRP-1:0] disp_mem,
    output logic [1:0]                  sleep_mode,
    output logic [1:0]                  port_sel,
    output logic                        seg_enable,
    output logic                        bias_third
);
    localparam int DISP_W = GRP_BITS * NUM_GRP;
    localparam int TAIL_W = $bits(scp_ctrl_t);
    localparam int GID_W  = (NUM_GRP > 1) ? $clog2(NUM_GRP) : 1;
    localparam int PAY_W  = GRP_BITS + TAIL_W + GID_W;
    localparam int RD_W   = KEY_W + 1;

    logic             sck_rise, sck_fall, ce_fall;
    logic             rd_start, commit;
    logic [PAY_W-1:0] pay;
    logic [GID_W-1:0] grp_id;
    scp_ctrl_t        ctrl_q;
    logic [GRP_BITS-1:0] grp_q [NUM_GRP];

    scp_edge_det u_edge (
        .clk      (clk),
        .rst_n    (rst_n),
        .ser_clk  (ser_clk),
        .ser_ce   (ser_ce),
        .sck_rise (sck_rise),
        .sck_fall (sck_fall),
        .ce_fall  (ce_fall)
    );

    scp_frame_rx #(
        .ADDR_W  (ADDR_W),
        .PAY_W   (PAY_W),
        .WR_ADDR (WR_ADDR),
        .RD_ADDR (RD_ADDR)
    ) u_rx (
        .clk      (clk),
        .rst_n    (rst_n),
        .ser_ce   (ser_ce),
        .ser_din  (ser_din),
        .sck_rise (sck_rise),
        .ce_fall  (ce_fall),
        .rd_start (rd_start),
        .commit   (commit),
        .pay_q    (pay)
    );

    scp_read_tx #(
        .RD_W (RD_W)
    ) u_tx (
        .clk       (clk),
        .rst_n     (rst_n),
        .ser_ce    (ser_ce),
        .load      (rd_start),
        .load_word ({sleep_ack, key_in}),
        .sck_fall  (sck_fall),
        .dout      (ser_dout)
    );

    assign grp_id = pay[PAY_W-1 -: GID_W];

    // One register bank per display group, loaded when its number commits.
    for (genvar g = 0; g < NUM_GRP; g++) begin : g_grp
        always_ff @(posedge clk) begin
            if (!rst_n)                                   grp_q[g] <= '0;
            else if (commit && (grp_id == GID_W'(g)))     grp_q[g] <= pay[GRP_BITS-1:0];
        end
        assign disp_mem[g*GRP_BITS +: GRP_BITS] = grp_q[g];
    end

    // Control register follows the tail of a committed group 0 only.
    always_ff @(posedge clk) begin
        if (!rst_n)                          ctrl_q <= '0;
        else if (commit && (grp_id == '0))   ctrl_q <= scp_ctrl_t'(pay[GRP_BITS +: TAIL_W]);
    end

    assign sleep_mode = ctrl_q.sleep_mode;
    assign port_sel   = ctrl_q.port_sel;
    assign seg_enable = ctrl_q.seg_enable;
    assign bias_third = ctrl_q.bias_third;
endmodule

// File: rtl/serial_cmd_port_chk.sv
// Checker for serial_cmd_port: port-level timing rules of data-out and of
// register updates. Attached to every instance by the bind below.
module serial_cmd_port_chk #(
    parameter int DISP_W = 126
) (
    input logic              clk,
    input logic              rst_n,
    input logic              ser_ce,
    input logic              ser_clk,
    input logic              ser_dout,
    input logic [DISP_W-1:0] disp_mem,
    input logic [5:0]        ctrl_flat
);
    // R7: data-out is released the cycle after chip-enable is seen low.
    p_dout_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !ser_ce |=> ser_dout);

    // R6: data-out moves only after a serial clock fall or a chip-enable drop.
    p_dout_on_fall_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(ser_dout) |-> (!$past(ser_ce) || ($past(ser_clk, 2) && !$past(ser_clk))));

    // R5: the display image changes only right after chip-enable falls.
    p_disp_commit_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(disp_mem) |-> (!$past(ser_ce) && $past(ser_ce, 2)));

    // R4: the control register changes only right after chip-enable falls.
    p_ctrl_commit_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(ctrl_flat) |-> (!$past(ser_ce) && $past(ser_ce, 2)));
endmodule

bind serial_cmd_port serial_cmd_port_chk #(.DISP_W(DISP_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .ser_ce    (ser_ce),
    .ser_clk   (ser_clk),
    .ser_dout  (ser_dout),
    .disp_mem  (disp_mem),
    .ctrl_flat ({bias_third, seg_enable, port_sel, sleep_mode})
);

// File: tb/tb_serial_cmd_port.sv
`timescale 1ns/1ps
module tb_serial_cmd_port;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         ser_ce = 1'b0, ser_clk = 1'b0, ser_din = 1'b0;
    logic         ser_dout;
    logic [29:0]  key_in = '0;
    logic         sleep_ack = 1'b0;
    logic [125:0] disp_mem;
    logic [1:0]   sleep_mode, port_sel;
    logic         seg_enable, bias_third;

    int total = 0;
    int bad = 0;
    bit done = 0;
    bit dout_low_seen;
    logic [125:0] exp_disp = '0;
    logic [5:0]   exp_ctrl = '0;

    always #2 clk = ~clk;

    serial_cmd_port dut (
        .clk(clk), .rst_n(rst_n), .ser_ce(ser_ce), .ser_clk(ser_clk),
        .ser_din(ser_din), .ser_dout(ser_dout), .key_in(key_in),
        .sleep_ack(sleep_ack), .disp_mem(disp_mem), .sleep_mode(sleep_mode),
        .port_sel(port_sel), .seg_enable(seg_enable), .bias_third(bias_third)
    );

    // Write payloads: {group, tail bias/seg/P1/P0/S1/S0, 42 display bits}.
    localparam logic [49:0] VEC [6] = '{
        {2'd0, 6'b100101, 42'h2AA_AAAA_AAAA},
        {2'd1, 6'b111111, 42'h155_5555_5555},
        {2'd2, 6'b000000, 42'h000_0000_0001},
        {2'd2, 6'b010110, 42'h200_0000_0000},
        {2'd3, 6'b111111, 42'h3FF_FFFF_FFFF},
        {2'd0, 6'b011010, 42'h0F0_F0F0_F0F0}
    };

    task automatic chk(input bit ok, input string tag, input logic [127:0] act,
                       input logic [127:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic half();
        repeat (2) @(negedge clk);
    endtask

    // One serial bit: fall, set data, rise; also watch data-out for writes.
    task automatic sbit(input logic b);
        ser_clk = 1'b0;
        ser_din = b;
        half();
        if (ser_dout !== 1'b1) dout_low_seen = 1;
        ser_clk = 1'b1;
        half();
    endtask

    task automatic send_frame(input logic [7:0] addr, input logic [63:0] pay,
                              input int nbits, input logic idle);
        ser_clk = idle;
        half();
        ser_ce = 1'b1;
        half();
        for (int i = 0; i < 8; i++) sbit(addr[i]);
        for (int i = 0; i < nbits; i++) sbit(pay[i]);
        ser_clk = idle;
        half();
        ser_ce = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    task automatic model_write(input logic [49:0] p);
        if (p[49:48] != 2'd3) exp_disp[p[49:48]*42 +: 42] = p[41:0];
        if (p[49:48] == 2'd0) exp_ctrl = p[47:42];
    endtask

    task automatic chk_state(input string tag);
        chk(disp_mem === exp_disp, {tag, " disp"}, 128'(disp_mem), 128'(exp_disp));
        chk({bias_third, seg_enable, port_sel, sleep_mode} === exp_ctrl, {tag, " ctrl"},
            128'({bias_third, seg_enable, port_sel, sleep_mode}), 128'(exp_ctrl));
    endtask

    // Read transfer: snapshot at address end, then 31 bits and one release.
    task automatic do_read(input logic idle, input logic [29:0] keys, input logic sa,
                           input string tag);
        logic [30:0] got;
        logic [30:0] want;
        want = {sa, keys};
        key_in = keys;
        sleep_ack = sa;
        ser_clk = idle;
        half();
        ser_ce = 1'b1;
        half();
        for (int i = 0; i < 8; i++) sbit(8'h43 >> i);
        key_in = ~keys;           // R6: later changes must not reach the read
        sleep_ack = ~sa;
        for (int i = 0; i < 31; i++) begin
            ser_clk = 1'b0;
            half();
            got[i] = ser_dout;
            ser_clk = 1'b1;
            half();
        end
        chk(got === want, {tag, " R6 read order"}, 128'(got), 128'(want));
        ser_clk = 1'b0;
        half();
        chk(ser_dout === 1'b1, {tag, " R7 release after SA"}, 128'(ser_dout), 128'(1));
        ser_clk = idle;
        half();
        ser_ce = 1'b0;
        repeat (4) @(negedge clk);
        chk(ser_dout === 1'b1, {tag, " R7 idle"}, 128'(ser_dout), 128'(1));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk_state("R1 reset");
        chk(ser_dout === 1'b1, "R1 reset dout", 128'(ser_dout), 128'(1));

        // R3 R4 R5 R8: table of write frames, alternating clock idle level.
        dout_low_seen = 0;
        for (int i = 0; i < 6; i++) begin
            send_frame(8'h42, 64'(VEC[i]), 50, logic'(i % 2));
            model_write(VEC[i]);
            chk_state($sformatf("R3 R4 R8 vec%0d", i));
        end
        chk(!dout_low_seen, "R7 dout during writes", 128'(dout_low_seen), 128'(0));

        // R5: short and long frames are discarded.
        send_frame(8'h42, 64'({2'd1, 6'b0, 42'h3FF_FFFF_FFFF}), 49, 1'b0);
        chk_state("R5 short frame");
        send_frame(8'h42, 64'({2'd1, 6'b0, 42'h3FF_FFFF_FFFF}), 51, 1'b1);
        chk_state("R5 long frame");

        // R2: an unknown address changes nothing and leaves data-out released.
        dout_low_seen = 0;
        send_frame(8'h41, 64'({2'd0, 6'b111111, 42'h3FF_FFFF_FFFF}), 50, 1'b0);
        chk_state("R2 foreign address");
        chk(!dout_low_seen, "R2 dout foreign", 128'(dout_low_seen), 128'(0));

        // R6 R8: reads with both idle levels.
        do_read(1'b0, 30'h2345_6789, 1'b1, "idle-low");
        do_read(1'b1, 30'h1C3A_5F00, 1'b0, "idle-high R8");
        chk_state("R2 read leaves registers");

        // R9: group 0 with zero sleep bits leaves sleep.
        chk(sleep_mode !== 2'b00, "R9 precondition", 128'(sleep_mode), 128'(2));
        send_frame(8'h42, 64'({2'd0, 6'b110000, 42'h001_2345_6789}), 50, 1'b1);
        model_write({2'd0, 6'b110000, 42'h001_2345_6789});
        chk(sleep_mode === 2'b00, "R9 sleep cleared", 128'(sleep_mode), 128'(0));
        chk_state("R9 state");

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule